// File: doc/BRIEF.md
# Nibble-Striped Hamming Lane Codec

This block protects a byte stream that is stored across seven bit-wide lanes kept in lockstep. On the write side it takes one byte at a time and cuts it into two 4-bit halves. Each half becomes a 7-bit single-error-correcting Hamming codeword, and that word goes out in one transfer with one codeword bit on each lane. So every byte costs two lane transfers and six check bits.

On the read side, seven-bit lane words come back in the same order. Each word is checked, and a single flipped bit is repaired before its four data bits are taken out. The halves are then joined back into a byte. Every bit a lane carries sits at the same codeword position in every word. A lane that has failed outright therefore damages at most one bit per codeword, and the stream is still recovered without loss.

Every edge has a valid/ready handshake: byte in, lane word out, lane word in, byte out. With the result byte the decoder returns a 3-bit syndrome and a corrected flag for each half.

Top module: `nibble_lane_codec`

## Requirements
- R1: The encoder sends the low nibble (byte bits 3:0) as the first codeword and the high nibble as the second. The decoder treats the first codeword it accepts after reset or after a finished byte as the low nibble, and the second as the high nibble.
- R2: Lane bit i carries codeword position i+1. Positions 1, 2 and 4 hold check bits. Positions 3, 5, 6 and 7 hold nibble bits 0, 1, 2 and 3. Each check bit at position 2^k gives even parity over all positions whose index has bit k set.
- R3: While the lane output is valid and not accepted, the lane word and its valid stay unchanged. With the lane sink always ready, bytes are taken with no idle cycle, one byte per two lane transfers.
- R4: A received codeword with zero syndrome is used as it is, with syndrome 0 and corrected flag 0.
- R5: For a received codeword with exactly one bit flipped at position p, the syndrome reported for that half is p (bit 0 = parity over positions with index bit 0 set, and so on), the corrected flag is 1, and the nibble is restored.
- R6: With any single lane stuck at 0 for the whole stream, every byte is still delivered intact.
- R7: The output byte becomes valid only after both codewords have been decoded. While it is valid and not accepted, it and its syndromes stay unchanged.
- R8: A synchronous active-high reset drops both valid outputs, makes the byte input ready, and discards any half-assembled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Input byte valid |
| wr_ready | output | 1 | Encoder can take a byte |
| wr_byte | input | 8 | Byte to encode |
| lane_tx_valid | output | 1 | Outgoing lane word valid |
| lane_tx_ready | input | 1 | Lane sink accepts the word |
| lane_tx | output | 7 | Outgoing codeword, one bit per lane |
| lane_rx_valid | input | 1 | Incoming lane word valid |
| lane_rx_ready | output | 1 | Decoder accepts the word |
| lane_rx | input | 7 | Incoming codeword, one bit per lane |
| rd_valid | output | 1 | Decoded byte valid |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_byte | output | 8 | Decoded byte |
| rd_syn_lo | output | 3 | Syndrome of the low-nibble codeword |
| rd_syn_hi | output | 3 | Syndrome of the high-nibble codeword |
| rd_fix_lo | output | 1 | Low-nibble codeword was corrected |
| rd_fix_hi | output | 1 | High-nibble codeword was corrected |

## Verification
The assertions check on every cycle that each emitted lane word is a valid codeword, that a lane word or byte held under backpressure does not change, that the low codeword of a byte is always followed by its high one, and that reset drops both valid outputs. The following can only be shown by the bench's scenarios, because they need values computed apart from the design: the bit layout and nibble order, the syndrome value for a flip at each of the seven positions in either half, recovery with every lane stuck in turn, and that a reset between the two halves of a byte restarts the pairing.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 3;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int BYTE_W = 2 * DATA_W;

  // place data bits at non-power-of-two positions, then fill even-parity checks
  function automatic logic [CW_W-1:0] hlc_encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w;
    logic par;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[j];
        j++;
      end
    end
    for (int k = 0; k < CHK_W; k++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> k) & 1) == 1) par = par ^ w[p-1];
      end
      w[(1 << k) - 1] = par;
    end
    return w;
  endfunction

  function automatic logic [CHK_W-1:0] hlc_syndrome(input logic [CW_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ w[p-1];
      end
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] hlc_extract(input logic [CW_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = w[p-1];
        j++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/hlc_encoder.sv
module hlc_encoder
  import hlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW_W-1:0]   out_word
);
  logic [CW_W-1:0]   word_q;
  logic [DATA_W-1:0] hi_q;
  logic              second_q;
  logic              valid_q;

  // free when empty, or when the high word leaves this cycle
  assign in_ready  = !valid_q || (second_q && out_ready);
  assign out_valid = valid_q;
  assign out_word  = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      second_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      word_q   <= hlc_encode(in_byte[DATA_W-1:0]);
      hi_q     <= in_byte[BYTE_W-1:DATA_W];
      second_q <= 1'b0;
      valid_q  <= 1'b1;
    end else if (valid_q && out_ready) begin
      if (!second_q) begin
        word_q   <= hlc_encode(hi_q);
        second_q <= 1'b1;
      end else begin
        valid_q  <= 1'b0;
      end
    end
  end

  AST_TX_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (hlc_syndrome(out_word) == '0)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R3
  AST_TX_PAIR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !second_q) |=> out_valid); // R1
  AST_TX_RESET: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

// File: rtl/hlc_decoder.sv
module hlc_decoder
  import hlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CW_W-1:0]   in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic [CHK_W-1:0]  out_syn_lo,
  output logic [CHK_W-1:0]  out_syn_hi
);
  logic [CHK_W-1:0]  syn;
  logic [CW_W-1:0]   fixed;
  logic [DATA_W-1:0] nib;
  logic              have_lo_q;
  logic [DATA_W-1:0] lo_q;
  logic [CHK_W-1:0]  lo_syn_q;
  logic              valid_q;
  logic [BYTE_W-1:0] byte_q;
  logic [CHK_W-1:0]  syn_lo_q;
  logic [CHK_W-1:0]  syn_hi_q;

  always_comb begin
    syn   = hlc_syndrome(in_word);
    fixed = in_word;
    for (int p = 1; p <= CW_W; p++) begin
      if (syn == CHK_W'(p)) fixed[p-1] = ~in_word[p-1];
    end
    nib = hlc_extract(fixed);
  end

  // a low half can always be stored; a high half needs the output slot
  assign in_ready   = !have_lo_q || !valid_q || out_ready;
  assign out_valid  = valid_q;
  assign out_byte   = byte_q;
  assign out_syn_lo = syn_lo_q;
  assign out_syn_hi = syn_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_lo_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (in_valid && in_ready) begin
        if (!have_lo_q) begin
          lo_q      <= nib;
          lo_syn_q  <= syn;
          have_lo_q <= 1'b1;
        end else begin
          byte_q    <= {nib, lo_q};
          syn_lo_q  <= lo_syn_q;
          syn_hi_q  <= syn;
          valid_q   <= 1'b1;
          have_lo_q <= 1'b0;
        end
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)
      && $stable(out_syn_lo) && $stable(out_syn_hi))); // R7
  AST_RD_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !have_lo_q && !(valid_q && !out_ready)) |=> !out_valid); // R7
  AST_RD_FIXED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (hlc_syndrome(fixed) == '0 || syn == '0)); // R5
  AST_RD_RESET: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

// File: rtl/nibble_lane_codec.sv
module nibble_lane_codec
  import hlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              lane_tx_valid,
  input  logic              lane_tx_ready,
  output logic [CW_W-1:0]   lane_tx,
  input  logic              lane_rx_valid,
  output logic              lane_rx_ready,
  input  logic [CW_W-1:0]   lane_rx,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CHK_W-1:0]  rd_syn_lo,
  output logic [CHK_W-1:0]  rd_syn_hi,
  output logic              rd_fix_lo,
  output logic              rd_fix_hi
);
  hlc_encoder u_enc (
    .clk(clk), .rst(rst),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_byte(wr_byte),
    .out_valid(lane_tx_valid), .out_ready(lane_tx_ready), .out_word(lane_tx)
  );

  hlc_decoder u_dec (
    .clk(clk), .rst(rst),
    .in_valid(lane_rx_valid), .in_ready(lane_rx_ready), .in_word(lane_rx),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_byte(rd_byte),
    .out_syn_lo(rd_syn_lo), .out_syn_hi(rd_syn_hi)
  );

  assign rd_fix_lo = |rd_syn_lo;
  assign rd_fix_hi = |rd_syn_hi;
endmodule

// File: tb/tb_nibble_lane_codec.sv
`timescale 1ns/1ps
module tb_nibble_lane_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, lane_tx_ready = 1'b1, lane_rx_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_byte = '0;
  logic [6:0] lane_rx = '0;
  logic wr_ready, lane_tx_valid, lane_rx_ready, rd_valid, rd_fix_lo, rd_fix_hi;
  logic [6:0] lane_tx;
  logic [7:0] rd_byte;
  logic [2:0] rd_syn_lo, rd_syn_hi;

  int checks = 0, errors = 0, cyc = 0;
  bit tx_bp = 0, rd_bp = 0, done = 0;
  logic [6:0]  exp_tx[$];
  logic [15:0] exp_rd[$];
  logic tx_hold = 0, rd_hold = 0;
  logic [6:0]  tx_held;
  logic [13:0] rd_held;

  always #2 clk = ~clk;

  nibble_lane_codec dut (.*);

  // R2 layout written from the requirement: lane i = position i+1
  function automatic logic [6:0] cw(input logic [3:0] n);
    logic [6:0] w;
    w[0] = n[0] ^ n[1] ^ n[3];
    w[1] = n[0] ^ n[2] ^ n[3];
    w[2] = n[0];
    w[3] = n[1] ^ n[2] ^ n[3];
    w[4] = n[1];
    w[5] = n[2];
    w[6] = n[3];
    return w;
  endfunction

  function automatic logic [2:0] flip_pos(input logic [6:0] diff);
    logic [2:0] r = 3'd0;
    for (int i = 0; i < 7; i++) if (diff[i]) r = 3'(i + 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    lane_tx_ready = tx_bp ? (((cyc % 3) != 0) ? 1'b0 : 1'b1) : 1'b1;
    rd_ready      = rd_bp ? (((cyc % 4) == 1) ? 1'b1 : 1'b0) : 1'b1;
  end

  // monitor: scoreboard pops and hold-stability checks
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_hold) check("R3 tx hold", {24'd0, lane_tx_valid, lane_tx}, {24'd0, 1'b1, tx_held});
      if (rd_hold) check("R7 rd hold", {17'd0, rd_valid, rd_byte, rd_syn_lo, rd_syn_hi},
                         {17'd0, 1'b1, rd_held});
      tx_hold = lane_tx_valid && !lane_tx_ready;
      tx_held = lane_tx;
      rd_hold = rd_valid && !rd_ready;
      rd_held = {rd_byte, rd_syn_lo, rd_syn_hi};
      if (lane_tx_valid && lane_tx_ready) begin
        if (exp_tx.size() == 0) check("R1 unexpected lane word", {25'd0, lane_tx}, 32'hFFFF);
        else check("R1 R2 lane word", {25'd0, lane_tx}, {25'd0, exp_tx.pop_front()});
      end
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) check("R7 unexpected byte", {24'd0, rd_byte}, 32'hFFFF);
        else check("R4 R5 R6 byte/syndrome/flags",
                   {16'd0, rd_byte, rd_syn_lo, rd_syn_hi, rd_fix_lo, rd_fix_hi},
                   {16'd0, exp_rd.pop_front()});
      end
    end else begin
      tx_hold = 0;
      rd_hold = 0;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    exp_tx.push_back(cw(b[3:0]));
    exp_tx.push_back(cw(b[7:4]));
    wr_byte = b;
    wr_valid = 1'b1;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic send_cw(input logic [6:0] w);
    lane_rx = w;
    lane_rx_valid = 1'b1;
    @(negedge clk);
    while (!lane_rx_ready) @(negedge clk);
    @(posedge clk); #1;
    lane_rx_valid = 1'b0;
  endtask

  // stuck < 0 means no stuck lane
  task automatic send_rx(input logic [7:0] b, input logic [6:0] flo, input logic [6:0] fhi,
                         input int stuck);
    logic [6:0] lo, hi;
    logic [2:0] slo, shi;
    lo = cw(b[3:0]) ^ flo;
    hi = cw(b[7:4]) ^ fhi;
    if (stuck >= 0) begin
      lo[stuck] = 1'b0;
      hi[stuck] = 1'b0;
    end
    slo = flip_pos(lo ^ cw(b[3:0]));
    shi = flip_pos(hi ^ cw(b[7:4]));
    exp_rd.push_back({b, slo, shi, slo != 3'd0, shi != 3'd0});
    send_cw(lo);
    send_cw(hi);
  endtask

  task automatic drain();
    while (exp_tx.size() != 0 || exp_rd.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R8 tx valid after reset", {31'd0, lane_tx_valid}, 0);
    check("R8 rd valid after reset", {31'd0, rd_valid}, 0);
    check("R8 wr ready after reset", {31'd0, wr_ready}, 1);
    @(posedge clk); #1;

    // R1 R2: encoder, fixed patterns and every nibble value
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'hA5); send_byte(8'h3C);
    for (int i = 0; i < 16; i++) send_byte(8'((i << 4) | (15 - i)));
    drain();

    // R3: back-to-back throughput with sink always ready
    begin
      int t0;
      t0 = cyc;
      for (int i = 0; i < 8; i++) send_byte(8'(i * 37 + 5));
      drain();
      check("R3 eight bytes accepted back to back", 32'(cyc - t0 <= 8 + 7 + 6), 1);
    end

    // R3: encoder under backpressure
    tx_bp = 1;
    for (int i = 0; i < 10; i++) send_byte(8'(i * 91 + 3));
    drain();
    tx_bp = 0;

    // R4: clean decode
    send_rx(8'h00, 0, 0, -1); send_rx(8'hFF, 0, 0, -1); send_rx(8'h96, 0, 0, -1);
    drain();

    // R5: single flip at each position in each half
    for (int p = 0; p < 7; p++) begin
      send_rx(8'(8'h5A + p), 7'(1 << p), 7'd0, -1);
      send_rx(8'(8'hC3 ^ p), 7'd0, 7'(1 << p), -1);
      send_rx(8'(8'h71 + 16 * p), 7'(1 << p), 7'(1 << (6 - p)), -1);
    end
    drain();

    // R6 R7: each lane stuck at 0 under output backpressure
    rd_bp = 1;
    for (int l = 0; l < 7; l++)
      for (int k = 0; k < 6; k++) send_rx(8'(k * 43 + l * 17 + 1), 7'd0, 7'd0, l);
    drain();
    rd_bp = 0;

    // R7: lone low half gives no byte; R8: reset discards it
    send_cw(cw(4'h9));
    repeat (4) @(negedge clk);
    check("R7 no byte after one codeword", {31'd0, rd_valid}, 0);
    @(posedge clk); #1;
    do_reset();
    @(negedge clk);
    check("R8 rd valid low after reset", {31'd0, rd_valid}, 0);
    @(posedge clk); #1;
    send_rx(8'h4E, 0, 0, -1);
    drain();
    check("R1 R8 queues empty", 32'(exp_tx.size() + exp_rd.size()), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule